// File: doc/BRIEF.md
# Reward-Modulated Spike-Timing Synapse Updater

This block keeps the learned strength of a bank of synapses that all feed one post-synaptic neuron. It watches which inputs fire and when the neuron fires, counted in discrete time steps marked by a tick strobe. An input that fires shortly before the neuron is rewarded. An input that fires shortly after the neuron is punished. A signed modulator value, which stands for a global reward signal, scales the size of every change and sets its sign.

Each synapse holds two unsigned components. One collects strengthening and the other collects weakening. The effective weight is the first minus the second. Changes happen only on ticks that carry a spike event. The size of a step falls off with the spacing between the two spikes. Both components clamp at their bounds and never wrap. A read port selects one synapse and returns both components and the signed weight with no clock delay.

Top module: `stdp_updater`

## Requirements
- R1: After reset every strengthening and weakening component is 0, every weight reads 0, and no past spike is remembered.
- R2: When the post input is 1 on a tick, and synapse i's pre bit is 0 on that tick, and synapse i's most recent pre spike came g ticks earlier with 1 <= g <= window, the strengthening component of synapse i changes by sign(mod) * (|mod| >> (g/4)).
- R3: When synapse i's pre bit is 1 on a tick, the post input is 0 on that tick, and the most recent post spike came g ticks earlier with 1 <= g <= window, the weakening component of synapse i changes by sign(mod) * (|mod| >> (g/4)).
- R4: Spike pairs spaced more than the window input apart change nothing. A window value of 0 blocks every update.
- R5: If synapse i's pre bit and the post input are both 1 on the same tick, synapse i is not updated on that tick. Both spikes are still recorded as the most recent ones.
- R6: A modulator of 0 leaves every component unchanged. A negative modulator lowers the component that a positive one would raise.
- R7: Components are 8-bit and saturate: an increase stops at 255 and a decrease stops at 0.
- R8: Spike inputs have no effect on cycles where the tick input is 0. Spike ages advance only on ticks.
- R9: The read port returns the strengthening component, the weakening component and their signed difference for the synapse selected by the index, in the same cycle.
- R10: Only the most recent spike of each input, and of the post neuron, is remembered. A spike that is 32 or more ticks old is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-step strobe; spikes are sampled and ages advance only when it is 1 |
| pre_spk_i | input | N_SYN | One pre-synaptic spike bit per synapse |
| post_spk_i | input | 1 | Post-synaptic spike bit |
| mod_i | input | 8 | Signed reward modulator, two's complement |
| win_i | input | 5 | Pairing window in ticks (1 to 31; 0 disables learning) |
| rd_idx_i | input | log2(N_SYN) | Synapse selected for reading |
| rd_ltp_o | output | 8 | Strengthening component of the selected synapse |
| rd_ltd_o | output | 8 | Weakening component of the selected synapse |
| rd_weight_o | output | 9 | Signed effective weight of the selected synapse |

## Verification
Two corner cases are hard to reach. The first is the far edge of the age memory: a pair 31 ticks apart must still count, with the largest shift of 7, while a pair 32 ticks apart must not. The stimulus sets the window to 31 and uses a modulator of -128, so the 31-tick pair still moves a component by exactly one. It then repeats with one extra idle tick and checks that nothing changes. Saturation at the top is reached by pairing one synapse over and over at a spacing of one tick with the largest positive modulator. Clamping at zero comes from a negative modulator on a component that is still small. A reference model in the bench tracks every age and component, so each tick's side effects on the other synapses are also checked.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    // Widths that set the datapath of the updater
    localparam int AGE_W         = 5;   // tick age counter width, also window width
    localparam int COMP_W        = 8;   // each weight component
    localparam int MOD_W         = 8;   // signed modulator
    localparam int GAP_SHIFT_LOG = 2;   // step shift = gap >> GAP_SHIFT_LOG

    localparam int SUM_W = ((COMP_W > MOD_W) ? COMP_W : MOD_W) + 2;
    localparam logic [AGE_W-1:0]  AGE_MAX  = {AGE_W{1'b1}};
    localparam logic [COMP_W-1:0] COMP_MAX = {COMP_W{1'b1}};

    typedef logic        [AGE_W-1:0]  age_t;
    typedef logic        [COMP_W-1:0] comp_t;
    typedef logic signed [MOD_W-1:0]  mod_t;
    typedef logic        [MOD_W-1:0]  mag_t;

    typedef enum logic [1:0] {
        PAIR_NONE = 2'd0,
        PAIR_LTP  = 2'd1,
        PAIR_LTD  = 2'd2
    } pair_kind_e;

    typedef struct packed {
        pair_kind_e kind;
        age_t       gap;
    } pair_t;

    // Magnitude of the modulator, attenuated by the spike spacing
    function automatic mag_t step_mag(input mod_t m, input age_t gap);
        mag_t a;
        a = m[MOD_W-1] ? mag_t'(-m) : mag_t'(m);
        return a >> (gap >> GAP_SHIFT_LOG);
    endfunction

    // Saturating add or subtract on one component
    function automatic comp_t sat_step(input comp_t c, input mag_t mag, input logic neg);
        logic [SUM_W-1:0] cw;
        logic [SUM_W-1:0] mw;
        logic [SUM_W-1:0] sum;
        cw = SUM_W'(c);
        mw = SUM_W'(mag);
        if (neg) begin
            return (mw >= cw) ? '0 : COMP_W'(cw - mw);
        end
        sum = cw + mw;
        return (sum > SUM_W'(COMP_MAX)) ? COMP_MAX : COMP_W'(sum);
    endfunction

endpackage

// File: rtl/stdp_age_tracker.sv
module stdp_age_tracker
    import stdp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic spike_i,
    output age_t age_o
);
    // age 0 = nothing remembered; 1..AGE_MAX = ticks since last spike
    age_t age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (tick_i) begin
            if (spike_i) begin
                age_q <= age_t'(1);
            end else if (age_q == AGE_MAX) begin
                age_q <= '0;
            end else if (age_q != '0) begin
                age_q <= age_q + age_t'(1);
            end
        end
    end

    assign age_o = age_q;

    assert_age_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (tick_i && spike_i) |=> (age_o == age_t'(1)))
        else $error("age not restarted by spike");

    assert_age_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(age_o))
        else $error("age moved without tick");

    assert_age_expire_R10: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !spike_i && age_o == AGE_MAX) |=> (age_o == '0))
        else $error("old spike not forgotten");

endmodule

// File: rtl/stdp_pair_detect.sv
module stdp_pair_detect
    import stdp_pkg::*;
(
    input  logic  pre_spk_i,
    input  logic  post_spk_i,
    input  age_t  pre_age_i,
    input  age_t  post_age_i,
    input  age_t  win_i,
    output pair_t pair_o
);
    logic pre_in_win;
    logic post_in_win;

    always_comb begin
        pre_in_win  = (pre_age_i  != '0) && (pre_age_i  <= win_i);
        post_in_win = (post_age_i != '0) && (post_age_i <= win_i);
        pair_o.kind = PAIR_NONE;
        pair_o.gap  = '0;
        if (pre_spk_i && post_spk_i) begin
            pair_o.kind = PAIR_NONE;
        end else if (post_spk_i && pre_in_win) begin
            pair_o.kind = PAIR_LTP;
            pair_o.gap  = pre_age_i;
        end else if (pre_spk_i && post_in_win) begin
            pair_o.kind = PAIR_LTD;
            pair_o.gap  = post_age_i;
        end
    end

    always_comb begin
        assert_same_tick_R5: assert (!(pre_spk_i && post_spk_i) || pair_o.kind == PAIR_NONE)
            else $error("coincident spikes produced a pair");
    end

endmodule

// File: rtl/stdp_syn_cell.sv
module stdp_syn_cell
    import stdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  pair_t pair_i,
    input  mod_t  mod_i,
    output comp_t ltp_o,
    output comp_t ltd_o
);
    comp_t ltp_q;
    comp_t ltd_q;
    mag_t  mag;
    logic  neg;
    logic  active;

    always_comb begin
        mag    = step_mag(mod_i, pair_i.gap);
        neg    = mod_i[MOD_W-1];
        active = tick_i && (mod_i != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ltp_q <= '0;
            ltd_q <= '0;
        end else if (active) begin
            case (pair_i.kind)
                PAIR_LTP: ltp_q <= sat_step(ltp_q, mag, neg);
                PAIR_LTD: ltd_q <= sat_step(ltd_q, mag, neg);
                default:  ;
            endcase
        end
    end

    assign ltp_o = ltp_q;
    assign ltd_o = ltd_q;

    assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(ltp_o) && $stable(ltd_o)))
        else $error("component moved without tick");

    assert_zero_mod_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mod_i == '0) |=> ($stable(ltp_o) && $stable(ltd_o)))
        else $error("zero modulator changed a component");

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && pair_i.kind == PAIR_LTP && !mod_i[MOD_W-1]) |=> (ltp_o >= $past(ltp_o)))
        else $error("strengthening component wrapped");

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && pair_i.kind == PAIR_LTD && mod_i[MOD_W-1]) |=> (ltd_o <= $past(ltd_o)))
        else $error("weakening component wrapped");

    assert_single_side_R2: assert property (@(posedge clk) disable iff (rst)
        (pair_i.kind == PAIR_LTP) |=> $stable(ltd_o))
        else $error("strengthening event touched weakening side");

endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
    import stdp_pkg::*;
#(
    parameter int N_SYN = 8,
    localparam int IDX_W = (N_SYN > 1) ? $clog2(N_SYN) : 1,
    localparam int WGT_W = COMP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic [N_SYN-1:0]        pre_spk_i,
    input  logic                    post_spk_i,
    input  logic signed [MOD_W-1:0] mod_i,
    input  logic [AGE_W-1:0]        win_i,
    input  logic [IDX_W-1:0]        rd_idx_i,
    output logic [COMP_W-1:0]       rd_ltp_o,
    output logic [COMP_W-1:0]       rd_ltd_o,
    output logic signed [WGT_W-1:0] rd_weight_o
);
    age_t  post_age;
    comp_t ltp_arr [N_SYN];
    comp_t ltd_arr [N_SYN];

    stdp_age_tracker u_post_age (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .spike_i (post_spk_i),
        .age_o   (post_age)
    );

    for (genvar s = 0; s < N_SYN; s++) begin : g_syn
        age_t  pre_age;
        pair_t pair;

        stdp_age_tracker u_pre_age (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (tick_i),
            .spike_i (pre_spk_i[s]),
            .age_o   (pre_age)
        );

        stdp_pair_detect u_pair (
            .pre_spk_i  (pre_spk_i[s]),
            .post_spk_i (post_spk_i),
            .pre_age_i  (pre_age),
            .post_age_i (post_age),
            .win_i      (win_i),
            .pair_o     (pair)
        );

        stdp_syn_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick_i),
            .pair_i (pair),
            .mod_i  (mod_i),
            .ltp_o  (ltp_arr[s]),
            .ltd_o  (ltd_arr[s])
        );

        assert_coincident_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (tick_i && pre_spk_i[s] && post_spk_i) |=> ($stable(ltp_arr[s]) && $stable(ltd_arr[s])))
            else $error("synapse updated on coincident spikes");

        assert_closed_window_R4: assert property (@(posedge clk) disable iff (rst)
            (win_i == '0) |=> ($stable(ltp_arr[s]) && $stable(ltd_arr[s])))
            else $error("update with window 0");
    end

    always_comb begin
        rd_ltp_o = '0;
        rd_ltd_o = '0;
        for (int i = 0; i < N_SYN; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_ltp_o = ltp_arr[i];
                rd_ltd_o = ltd_arr[i];
            end
        end
        rd_weight_o = $signed({1'b0, rd_ltp_o}) - $signed({1'b0, rd_ltd_o});
    end

endmodule

// File: tb/stdp_updater_tb.sv
`timescale 1ns/1ps
module stdp_updater_tb_top;
    localparam int NS = 8;

    logic              clk = 0;
    logic              rst;
    logic              tick_i;
    logic [NS-1:0]     pre_spk_i;
    logic              post_spk_i;
    logic signed [7:0] mod_i;
    logic [4:0]        win_i;
    logic [2:0]        rd_idx_i;
    logic [7:0]        rd_ltp_o;
    logic [7:0]        rd_ltd_o;
    logic signed [8:0] rd_weight_o;

    stdp_updater #(.N_SYN(NS)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .pre_spk_i(pre_spk_i),
        .post_spk_i(post_spk_i), .mod_i(mod_i), .win_i(win_i),
        .rd_idx_i(rd_idx_i), .rd_ltp_o(rd_ltp_o), .rd_ltd_o(rd_ltd_o),
        .rd_weight_o(rd_weight_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int    idx;
        int    ltp;
        int    ltd;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    // reference model, written from the requirements
    int m_pre [NS];
    int m_post;
    int m_ltp [NS];
    int m_ltd [NS];
    int cur_win;

    function automatic int clampc(input int v);
        if (v < 0)   return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int age_next(input int a, input bit spk);
        if (spk)     return 1;
        if (a == 0)  return 0;
        if (a == 31) return 0;
        return a + 1;
    endfunction

    function automatic void model_tick(input bit [NS-1:0] pre, input bit post, input int mod);
        for (int i = 0; i < NS; i++) begin
            int g;
            int kind;
            int amp;
            int d;
            kind = 0;
            g    = 0;
            if (pre[i] && post) kind = 0;
            else if (post && m_pre[i] != 0 && m_pre[i] <= cur_win) begin kind = 1; g = m_pre[i]; end
            else if (pre[i] && m_post != 0 && m_post <= cur_win) begin kind = 2; g = m_post; end
            amp = ((mod < 0) ? -mod : mod) >> (g / 4);
            d   = (mod < 0) ? -amp : amp;
            if (kind == 1) m_ltp[i] = clampc(m_ltp[i] + d);
            if (kind == 2) m_ltd[i] = clampc(m_ltd[i] + d);
        end
        for (int i = 0; i < NS; i++) m_pre[i] = age_next(m_pre[i], pre[i]);
        m_post = age_next(m_post, post);
    endfunction

    // driver: one tick with given spikes
    task automatic step(input bit [NS-1:0] pre, input bit post, input int mod);
        @(negedge clk);
        tick_i = 1; pre_spk_i = pre; post_spk_i = post; mod_i = 8'(mod);
        model_tick(pre, post, mod);
        @(negedge clk);
        tick_i = 0; pre_spk_i = '0; post_spk_i = 0;
    endtask

    task automatic idle(input int n, input int mod);
        for (int k = 0; k < n; k++) step('0, 0, mod);
    endtask

    // spikes with the tick low: model stays put
    task automatic no_tick_spikes(input bit [NS-1:0] pre, input bit post);
        @(negedge clk);
        tick_i = 0; pre_spk_i = pre; post_spk_i = post; mod_i = 8'sd100;
        @(negedge clk);
        pre_spk_i = '0; post_spk_i = 0;
    endtask

    // driver: queue expectations for all synapses
    task automatic check_all(input string req);
        for (int i = 0; i < NS; i++) begin
            exp_t e;
            @(negedge clk);
            rd_idx_i = 3'(i);
            e.idx = i; e.ltp = m_ltp[i]; e.ltd = m_ltd[i]; e.req = req;
            q.push_back(e);
        end
        @(negedge clk);
    endtask

    // monitor: pop and compare away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                int aw;
                e  = q.pop_front();
                aw = int'(rd_weight_o);
                n_checks++;
                if (int'(rd_ltp_o) != e.ltp || int'(rd_ltd_o) != e.ltd || aw != e.ltp - e.ltd) begin
                    n_fails++;
                    $display("FAIL %s syn %0d: ltp/ltd/w = %0d/%0d/%0d expected %0d/%0d/%0d",
                             e.req, e.idx, rd_ltp_o, rd_ltd_o, aw, e.ltp, e.ltd, e.ltp - e.ltd);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1; tick_i = 0; pre_spk_i = '0; post_spk_i = 0; mod_i = '0;
        win_i = 5'd8; rd_idx_i = '0;
        cur_win = 8;
        m_post = 0;
        for (int i = 0; i < NS; i++) begin m_pre[i] = 0; m_ltp[i] = 0; m_ltd[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");

        // R2: pre then post, gap 3 then gap 5
        step(8'h01, 0, 64); idle(2, 64); step('0, 1, 64);
        check_all("R2");
        step(8'h02, 0, 64); idle(4, 64); step('0, 1, 64);
        check_all("R2");

        // R3 and R9: post then pre, gap 4, negative weight read back
        idle(10, 64);
        step('0, 1, 64); idle(3, 64); step(8'h04, 0, 64);
        check_all("R3");
        check_all("R9");

        // R4: gap 9 beyond window 8, then window 0
        idle(10, 64);
        step(8'h08, 0, 64); idle(8, 64); step('0, 1, 64);
        check_all("R4");
        win_i = 5'd0; cur_win = 0;
        step(8'h10, 0, 64); step('0, 1, 64); step(8'h10, 0, 64);
        check_all("R4");
        win_i = 5'd8; cur_win = 8;

        // R5: coincident spikes on synapse 5
        idle(10, 64);
        step(8'h20, 1, 64);
        check_all("R5");
        step('0, 1, 64);
        check_all("R5");

        // R6: zero modulator, then negative modulator
        idle(10, 64);
        step(8'h40, 0, 0); step('0, 1, 0);
        check_all("R6");
        step(8'h01, 0, -32); step('0, 1, -32);
        check_all("R6");

        // R7: clamp at 0, then saturate at 255
        step(8'h40, 0, -64); step('0, 1, -64);
        check_all("R7");
        for (int k = 0; k < 6; k++) begin step(8'h80, 0, 127); step('0, 1, 127); end
        check_all("R7");

        // R8: spikes without tick are ignored
        idle(35, 64);
        no_tick_spikes(8'hFF, 1);
        check_all("R8");
        step('0, 1, 64);
        check_all("R8");

        // R10: edge of memory at 31 ticks, then forgotten at 32
        win_i = 5'd31; cur_win = 31;
        idle(35, -128);
        step(8'h01, 0, -128); idle(30, -128); step('0, 1, -128);
        check_all("R10");
        idle(35, -128);
        step(8'h02, 0, -128); idle(31, -128); step('0, 1, -128);
        check_all("R10");
        // newer pre replaces older one
        win_i = 5'd8; cur_win = 8;
        idle(35, 64);
        step(8'h08, 0, 64); idle(5, 64); step(8'h08, 0, 64); step('0, 1, 64);
        check_all("R10");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule